// File: doc/BRIEF.md
# Bus Wait-State and Data-Float Timer

This block times one access on an external memory bus. A single-cycle start request arrives with a read/write flag and a flag that says whether the access targets the slow, configurable region. Static configuration inputs then decide how long the access runs. A 2-bit active-low wait-select field sets how many extra state periods the read or write strobe is held. An active-low float-extension bit adds a dead period after reads. During that period the address drivers stay off, so that a slow memory has time to release the shared data lines.

When the float extension is enabled, only two wait counts can be chosen: 1 or 3. After a read in that mode, the controller holds the address-drive enable low for `FLOAT_CYCLES` state periods once the strobe ends. Accesses outside the configured region always run with no wait states and no float period. One down-counter times both the strobe stretch and the float gap. A one-cycle completion pulse marks the return to idle.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `strobe_en` is 0, `addr_drv_en` is 1 and `cyc_done` is 0.
- R2: For a selected-region access with `cfg_float_n`=1, the strobe is high for 1+W consecutive cycles starting the cycle after the start is accepted, where W is 0, 1, 2 or 3 for `cfg_wsel_n` of 11, 10, 01 or 00 respectively.
- R3: With `cfg_float_n`=0, a selected-region strobe lasts 2 cycles when `cfg_wsel_n[1]`=1 and 4 cycles when it is 0; `cfg_wsel_n[0]` has no effect.
- R4: After a selected-region read with `cfg_float_n`=0, `addr_drv_en` is low for exactly `FLOAT_CYCLES` cycles, starting the cycle after the strobe drops. The strobe is low throughout that period.
- R5: Writes never produce a float period: `addr_drv_en` stays 1 for every write in any configuration.
- R6: With `region_sel`=0, the strobe lasts exactly one cycle and no float period follows, whatever the configuration.
- R7: `cyc_done` is high for exactly one cycle: the first cycle after both the strobe and any float period have ended.
- R8: `cyc_start` is accepted only while idle (strobe low and address drive high, including the `cyc_done` cycle). A start raised while busy changes neither the strobe length nor the float length of the access already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state period per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | Request to begin an access |
| cyc_read | input | 1 | 1 for a read access, 0 for a write |
| region_sel | input | 1 | 1 when the access targets the configurable slow region |
| cfg_float_n | input | 1 | Active-low float-extension enable |
| cfg_wsel_n | input | 2 | Active-low wait-state select |
| strobe_en | output | 1 | Read/write strobe enable |
| addr_drv_en | output | 1 | Address-bus drive enable, low during a float period |
| cyc_done | output | 1 | One-cycle pulse when the access is complete |

## Verification
The bench builds the block with `FLOAT_CYCLES`=2. This separates the float length from the strobe length and makes the shared counter reload to a nonzero value for the float phase. With the configuration this small, the bench sweeps every combination of read/write, region flag, float bit and wait-select field. For each access it measures the strobe length, the float length and the position of the completion pulse against counts worked out arithmetically. A separate case holds the start request high into a busy access to show that the request is ignored.

// File: rtl/bus_timer_pkg.sv
// Package: shared types for the bus cycle timer.
// Assumes: one controller phase is active at a time.
package bus_timer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_FLOAT  = 2'd2
    } phase_t;

    // Largest wait count the decoder can produce
    localparam int unsigned WAIT_MAX = 3;

endpackage

// File: rtl/bt_wait_decode.sv
// Module: bt_wait_decode
// Turns the static configuration bits and per-access flags into a wait count
// and a decision on whether a float period follows the strobe.
// Assumes: configuration is stable while an access is being started.
module bt_wait_decode #(
    parameter int CNT_W = 2
) (
    input  logic             region_sel,
    input  logic             cyc_read,
    input  logic             cfg_float_n,
    input  logic [1:0]       cfg_wsel_n,
    output logic [CNT_W-1:0] wait_cnt,
    output logic             float_take
);

    // Wait count selection: restricted set when float extension is on
    always_comb begin
        if (!region_sel) begin
            wait_cnt = '0;
        end else if (cfg_float_n) begin
            wait_cnt = CNT_W'(2'd3 - cfg_wsel_n);
        end else begin
            wait_cnt = cfg_wsel_n[1] ? CNT_W'(1) : CNT_W'(3);
        end
    end

    // Float period only after reads in the region with extension enabled
    always_comb float_take = region_sel && cyc_read && !cfg_float_n;

endmodule

// File: rtl/bt_down_counter.sv
// Module: bt_down_counter
// Loadable down-counter that stops at zero; times both strobe and float phases.
// Assumes: load takes priority over decrement.
module bt_down_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, decrement toward zero, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero flag for the controller
    always_comb is_zero = (cnt_q == '0);

endmodule

// File: rtl/bt_phase_ctrl.sv
// Module: bt_phase_ctrl
// Sequences idle, strobe and float phases and produces the completion pulse.
// Assumes: FLOAT_CYCLES >= 1; the counter reports zero one cycle after loading zero.
module bt_phase_ctrl
    import bus_timer_pkg::*;
#(
    parameter int FLOAT_CYCLES = 1,
    parameter int CNT_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic             float_take,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output logic             strobe_en,
    output logic             addr_drv_en,
    output logic             cyc_done
);

    localparam logic [CNT_W-1:0] FLOAT_RELOAD = CNT_W'(FLOAT_CYCLES - 1);

    phase_t phase_q, phase_d;
    logic   float_q, float_d;
    logic   done_d;

    // Next phase, counter control and completion decision
    always_comb begin
        phase_d      = phase_q;
        float_d      = float_q;
        done_d       = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (cyc_start) begin
                    phase_d      = PH_STROBE;
                    float_d      = float_take;
                    cnt_load     = 1'b1;
                    cnt_load_val = wait_cnt;
                end
            end
            PH_STROBE: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (float_q) begin
                    phase_d      = PH_FLOAT;
                    cnt_load     = 1'b1;
                    cnt_load_val = FLOAT_RELOAD;
                end else begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_FLOAT: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State, float decision and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            float_q  <= 1'b0;
            cyc_done <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            float_q  <= float_d;
            cyc_done <= done_d;
        end
    end

    // Bus enables decoded from the registered phase
    always_comb begin
        strobe_en   = (phase_q == PH_STROBE);
        addr_drv_en = (phase_q != PH_FLOAT);
    end

endmodule

// File: rtl/bus_cycle_timer.sv
// Module: bus_cycle_timer (top)
// Times one external bus access: strobe stretch from the wait-select field
// and an optional float gap after reads in the configured region.
// Assumes: configuration inputs are static; cyc_start is ignored while busy.
module bus_cycle_timer
    import bus_timer_pkg::*;
#(
    parameter int FLOAT_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_read,
    input  logic       region_sel,
    input  logic       cfg_float_n,
    input  logic [1:0] cfg_wsel_n,
    output logic       strobe_en,
    output logic       addr_drv_en,
    output logic       cyc_done
);

    localparam int CNT_MAX = (FLOAT_CYCLES > int'(WAIT_MAX)) ? FLOAT_CYCLES : int'(WAIT_MAX);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             float_take;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic             cnt_zero;

    bt_wait_decode #(.CNT_W(CNT_W)) i_decode (
        .region_sel  (region_sel),
        .cyc_read    (cyc_read),
        .cfg_float_n (cfg_float_n),
        .cfg_wsel_n  (cfg_wsel_n),
        .wait_cnt    (wait_cnt),
        .float_take  (float_take)
    );

    bt_down_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    bt_phase_ctrl #(.FLOAT_CYCLES(FLOAT_CYCLES), .CNT_W(CNT_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .wait_cnt     (wait_cnt),
        .float_take   (float_take),
        .cnt_zero     (cnt_zero),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .cnt_dec      (cnt_dec),
        .strobe_en    (strobe_en),
        .addr_drv_en  (addr_drv_en),
        .cyc_done     (cyc_done)
    );

endmodule

// File: rtl/bus_cycle_timer_chk.sv
// Module: bus_cycle_timer_chk
// Port-level properties of the bus cycle timer, bound to the top module.
// Assumes: reset is asserted from time zero.
module bus_cycle_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic       cyc_read,
    input logic       region_sel,
    input logic       cfg_float_n,
    input logic [1:0] cfg_wsel_n,
    input logic       strobe_en,
    input logic       addr_drv_en,
    input logic       cyc_done
);

    logic       idle;
    logic       rd_float_q;
    logic [2:0] run_q;

    always_comb idle = !strobe_en && addr_drv_en;

    // Remember whether the accepted access may legally float
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_float_q <= 1'b0;
        end else if (cyc_start && idle) begin
            rd_float_q <= cyc_read && region_sel && !cfg_float_n;
        end
    end

    // Length of the current strobe run so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (strobe_en) begin
            run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!strobe_en && addr_drv_en && !cyc_done)); // R1
    AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (cyc_start && idle) |=> strobe_en); // R2
    AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) strobe_en |-> (run_q < 3'd4)); // R3
    AST_FLOAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !addr_drv_en |-> !strobe_en); // R4
    AST_FLOAT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !addr_drv_en |-> rd_float_q); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cyc_done |=> !cyc_done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cyc_done |-> idle); // R7

endmodule

bind bus_cycle_timer bus_cycle_timer_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .cyc_read    (cyc_read),
    .region_sel  (region_sel),
    .cfg_float_n (cfg_float_n),
    .cfg_wsel_n  (cfg_wsel_n),
    .strobe_en   (strobe_en),
    .addr_drv_en (addr_drv_en),
    .cyc_done    (cyc_done)
);

// File: tb/test_bus_cycle_timer.sv
// Bench: sweeps every configuration and access kind, measuring strobe,
// float and completion timing against arithmetically derived counts.
module test_bus_cycle_timer;

    localparam int FC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cyc_read = 1'b0;
    logic       region_sel = 1'b0;
    logic       cfg_float_n = 1'b1;
    logic [1:0] cfg_wsel_n = 2'b11;
    logic       strobe_en, addr_drv_en, cyc_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    bus_cycle_timer #(.FLOAT_CYCLES(FC)) i_bus_cycle_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_read    (cyc_read),
        .region_sel  (region_sel),
        .cfg_float_n (cfg_float_n),
        .cfg_wsel_n  (cfg_wsel_n),
        .strobe_en   (strobe_en),
        .addr_drv_en (addr_drv_en),
        .cyc_done    (cyc_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one access; hold keeps cyc_start high into the busy strobe
    task automatic run_case(input bit rd, input bit rg, input bit fl, input bit [1:0] ws, input bit hold);
        int w;
        int f;
        int strobes;
        int floats;
        int overlap;
        int done_at;
        string sreq;
        string freq;
        w = !rg ? 0 : (fl ? 3 - int'(ws) : (ws[1] ? 1 : 3));
        f = (rd && rg && !fl) ? FC : 0;
        sreq = !rg ? "R6" : (fl ? "R2" : "R3");
        freq = !rg ? "R6" : (rd ? "R4" : "R5");
        if (hold) sreq = "R8";
        @(negedge clk);
        cyc_read = rd; region_sel = rg; cfg_float_n = fl; cfg_wsel_n = ws;
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = hold;
        strobes = 0; floats = 0; overlap = 0; done_at = -1;
        for (int i = 0; i < 20; i++) begin
            if (strobe_en) strobes++;
            if (!addr_drv_en) floats++;
            if (strobe_en && !addr_drv_en) overlap++;
            if (cyc_done && done_at < 0) done_at = i;
            if (i == 2) cyc_start = 1'b0;
            if (done_at >= 0) break;
            @(negedge clk);
        end
        cyc_start = 1'b0;
        check(sreq, "strobe length", strobes, w + 1);
        check(freq, "float length", floats, f);
        check("R4", "strobe during float", overlap, 0);
        check("R7", "done position", done_at, w + 1 + f);
        @(negedge clk);
        check("R7", "done width", int'(cyc_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "strobe in reset", int'(strobe_en), 0);
        check("R1", "addr drive in reset", int'(addr_drv_en), 1);
        check("R1", "done in reset", int'(cyc_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "strobe after reset", int'(strobe_en), 0);
        check("R1", "done after reset", int'(cyc_done), 0);
        for (int rd = 0; rd < 2; rd++)
            for (int rg = 0; rg < 2; rg++)
                for (int fl = 0; fl < 2; fl++)
                    for (int ws = 0; ws < 4; ws++)
                        run_case(bit'(rd), bit'(rg), bit'(fl), 2'(ws), 1'b0);
        // R8: start held into a 4-cycle strobe, with float and without
        run_case(1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
        run_case(1'b1, 1'b1, 1'b0, 2'b01, 1'b1);
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule